// File: doc/BRIEF.md
# Double-Buffered Frame Scan Address Generator

This block generates the memory read addresses that fetch one frame of pixels, line by line, for a display pipeline. Software programs a pending frame base address whenever it likes. The pending base is promoted to the active base only on the frame-start pulse, so a frame that is already on the panel never changes base mid-scan. Panning and page flipping are therefore free of tearing. Vertical panning is done by pointing the pending base at `base + stride × line_offset`. A horizontal offset is not part of the scheme.

One packed register gives the frame shape: the active width in pixels and the active height in lines. A level input chooses the pixel size: 16-bit (2 bytes) or 32-bit (4 bytes). At each frame start the generator takes a snapshot of the shape and the pixel size. It then walks the frame in 32-bit words, each line starting at its own byte stride, and places the word addresses in a small request queue. A valid/ready read port drains the queue. A clear pulse empties the queue and halts the scan, so the pipeline can be reprogrammed safely. The next frame start resumes scanning.

Top module: `frame_scan_addr_gen`

## Requirements
- R1: A write of `next_base_in` with `next_we` high leaves `cur_base` unchanged until a cycle in which `vsync` is high. `cur_base` always reports the base of the frame being scanned.
- R2: On a clock edge where `vsync` is high, `cur_base` takes the pending base held before that edge. This happens whether or not `run` is high. A pending write in the same cycle as `vsync` is applied only at the following `vsync`.
- R3: `xfer_cnt` is packed as width in pixels in bits 15:0 and height in lines in bits 31:16. It is written with `xfer_we`. The shape and `pix32` are sampled at frame start, and a change during a frame has no effect until the next `vsync`.
- R4: With `pix32`=1 a pixel takes 4 bytes. With `pix32`=0 a pixel takes 2 bytes. The line stride in bytes is width × bytes per pixel. Each line takes ceil(width × bits per pixel / 32) words.
- R5: Word k of line j has the byte address ((base + j × stride) with bits 1:0 cleared) + 4k. Lines are issued in order from line 0. A frame issues exactly words-per-line × height addresses and then stops.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` hold. Each accepted request advances by exactly one word, and backpressure neither drops nor repeats an address.
- R7: A `vsync` that arrives during a frame discards every queued address and abandons the rest of that frame. Scanning restarts at the new base with word 0 of line 0.
- R8: A `fifo_clr` pulse drives `rd_valid` low on the next cycle. No request follows until a later `vsync` starts a frame. When `fifo_clr` and `vsync` occur in the same cycle, the base still swaps but no frame starts.
- R9: A `vsync` while `run` is low, or while the width or the height is zero, starts no frame and issues no request.
- R10: If the pending base is not rewritten, every `vsync` reloads the same base and repeats the same address sequence.
- R11: After reset `rd_valid` is low and both `cur_base` and the pending base equal `RESET_BASE` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Allows a frame to start at `vsync` |
| pix32 | input | 1 | Pixel size select: 1 = 32-bit, 0 = 16-bit |
| vsync | input | 1 | Frame-start pulse, one cycle |
| fifo_clr | input | 1 | Empties the request queue and halts the scan |
| next_we | input | 1 | Write strobe for the pending base |
| next_base_in | input | AW | Pending frame base byte address |
| xfer_we | input | 1 | Write strobe for the shape register |
| xfer_cnt | input | 32 | {height[31:16], width[15:0]} |
| cur_base | output | AW | Base of the frame being scanned |
| rd_valid | output | 1 | A read address is offered |
| rd_ready | input | 1 | The read port accepts the offered address |
| rd_addr | output | AW | Word-aligned byte address to read |

## Verification
If the active base is wrong, or is promoted at the wrong moment, the error shows on `cur_base` in the cycle after the faulty edge. It also shows on the first `rd_addr` of the next frame, which the bench compares against the base it wrote. If the column, line or stride state is wrong, the first misplaced word gives a wrong `rd_addr`. This is seen at the very next handshake, at the latest on the first word of the following line for stride faults. A frame that ends early or late is caught by counting accepted words and by watching that `rd_valid` stays low afterwards. Queue faults show as a missing, repeated or reordered address under throttled `rd_ready`, or as `rd_valid` high one cycle after a clear or a restart.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    localparam int CNT_W    = 16;          // width of each shape field
    localparam int XFER_W   = 2 * CNT_W;   // packed {height, width}
    localparam int WPL_W    = CNT_W + 1;   // words per line
    localparam int STRIDE_W = CNT_W + 2;   // bytes per line

    // words needed for one line: ceil(width * bpp / 32)
    function automatic logic [WPL_W-1:0] words_per_line(
        input logic [CNT_W-1:0] width,
        input logic             wide
    );
        logic [WPL_W-1:0] wx;
        wx = {1'b0, width};
        return wide ? wx : ((wx + WPL_W'(1)) >> 1);
    endfunction

    // byte stride of one line: width * bytes per pixel
    function automatic logic [STRIDE_W-1:0] line_stride(
        input logic [CNT_W-1:0] width,
        input logic             wide
    );
        return wide ? {width, 2'b00} : {1'b0, width, 1'b0};
    endfunction

endpackage

// File: rtl/fsa_base_regs.sv
module fsa_base_regs #(
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  RESET_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          next_we,
    input  logic [AW-1:0] next_in,
    input  logic          swap,
    output logic [AW-1:0] next_q,
    output logic [AW-1:0] cur_q
);

    typedef struct packed {
        logic [AW-1:0] pend;
        logic [AW-1:0] act;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // promotion uses the value held before this edge
        if (swap)
            st_d.act = st_q.pend;
        if (next_we)
            st_d.pend = next_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= RESET_BASE;
            st_q.act  <= RESET_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_q = st_q.pend;
    assign cur_q  = st_q.act;

endmodule

// File: rtl/fsa_scan_gen.sv
module fsa_scan_gen
    import fsa_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              stop,
    input  logic              xfer_we,
    input  logic [XFER_W-1:0] xfer_in,
    input  logic              pix32,
    input  logic [AW-1:0]     frame_base,
    input  logic              can_push,
    output logic              push,
    output logic [AW-1:0]     push_addr
);

    typedef struct packed {
        logic [XFER_W-1:0] xfer;
        logic              active;
        logic              wide;
        logic [CNT_W-1:0]  hcnt;
        logic [CNT_W-1:0]  vcnt;
        logic [WPL_W-1:0]  wpl;
        logic [WPL_W-1:0]  col;
        logic [CNT_W-1:0]  line;
        logic [AW-1:0]     line_base;
    } scan_st_t;

    scan_st_t st_d, st_q;

    logic [CNT_W-1:0] h_cfg, v_cfg;
    logic [AW-1:0]    stride_ext;
    logic [AW-1:0]    line_word;
    logic             push_c;
    logic             last_col, last_line;

    always_comb begin
        h_cfg      = st_q.xfer[CNT_W-1:0];
        v_cfg      = st_q.xfer[XFER_W-1:CNT_W];
        stride_ext = AW'(line_stride(st_q.hcnt, st_q.wide));
        line_word  = {st_q.line_base[AW-1:2], 2'b00};
        push_c     = st_q.active && can_push;
        last_col   = (st_q.col  == st_q.wpl  - WPL_W'(1));
        last_line  = (st_q.line == st_q.vcnt - CNT_W'(1));

        st_d = st_q;

        if (xfer_we)
            st_d.xfer = xfer_in;

        if (push_c) begin
            if (last_col) begin
                st_d.col = '0;
                if (last_line) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.line      = st_q.line + CNT_W'(1);
                    st_d.line_base = st_q.line_base + stride_ext;
                end
            end else begin
                st_d.col = st_q.col + WPL_W'(1);
            end
        end

        // frame start: snapshot shape and pixel size, rewind
        if (start) begin
            st_d.active    = run && (h_cfg != '0) && (v_cfg != '0);
            st_d.wide      = pix32;
            st_d.hcnt      = h_cfg;
            st_d.vcnt      = v_cfg;
            st_d.wpl       = words_per_line(h_cfg, pix32);
            st_d.col       = '0;
            st_d.line      = '0;
            st_d.line_base = frame_base;
        end

        // clear halts the scan and wins over a start
        if (stop)
            st_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign push      = push_c;
    assign push_addr = line_word + (AW'(st_q.col) << 2);

endmodule

// File: rtl/fsa_req_fifo.sv
module fsa_req_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] head
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop  && (st_q.cnt != '0);
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok)
                st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + PW'(1);
            if (pop_ok)
                st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + PW'(1);
            if (push_ok && !pop_ok)
                st_d.cnt = st_q.cnt + CW'(1);
            else if (pop_ok && !push_ok)
                st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush)
            mem[st_q.wr] <= din;
    end

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign valid = (st_q.cnt != '0);
    assign head  = mem[st_q.rd];

endmodule

// File: rtl/frame_scan_addr_gen.sv
module frame_scan_addr_gen
    import fsa_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            Q_DEPTH    = 4,
    parameter logic [AW-1:0] RESET_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pix32,
    input  logic              vsync,
    input  logic              fifo_clr,
    input  logic              next_we,
    input  logic [AW-1:0]     next_base_in,
    input  logic              xfer_we,
    input  logic [XFER_W-1:0] xfer_cnt,
    output logic [AW-1:0]     cur_base,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [AW-1:0]     rd_addr
);

    logic [AW-1:0] next_base_q;
    logic          q_full;
    logic          gen_push;
    logic [AW-1:0] gen_addr;
    logic          q_flush;

    // a new frame or a clear drops whatever is queued
    assign q_flush = vsync || fifo_clr;

    fsa_base_regs #(
        .AW         (AW),
        .RESET_BASE (RESET_BASE)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .next_we (next_we),
        .next_in (next_base_in),
        .swap    (vsync),
        .next_q  (next_base_q),
        .cur_q   (cur_base)
    );

    fsa_scan_gen #(
        .AW (AW)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (vsync),
        .run        (run),
        .stop       (fifo_clr),
        .xfer_we    (xfer_we),
        .xfer_in    (xfer_cnt),
        .pix32      (pix32),
        .frame_base (next_base_q),
        .can_push   (!q_full),
        .push       (gen_push),
        .push_addr  (gen_addr)
    );

    fsa_req_fifo #(
        .W     (AW),
        .DEPTH (Q_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (q_flush),
        .push  (gen_push),
        .din   (gen_addr),
        .pop   (rd_ready),
        .full  (q_full),
        .valid (rd_valid),
        .head  (rd_addr)
    );

endmodule

// File: rtl/frame_scan_chk.sv
module frame_scan_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vsync,
    input logic          fifo_clr,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] cur_base,
    input logic [AW-1:0] next_base
);

    // R1
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(cur_base));

    // R2
    base_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (cur_base == $past(next_base)));

    // R5
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_addr[1:0] == 2'b00));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !vsync && !fifo_clr) |=> (rd_valid && $stable(rd_addr)));

    // R8
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !rd_valid);

    // R7
    restart_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !rd_valid);

endmodule

bind frame_scan_addr_gen frame_scan_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync     (vsync),
    .fifo_clr  (fifo_clr),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .cur_base  (cur_base),
    .next_base (next_base_q)
);

// File: tb/tb_frame_scan_addr_gen.sv
`timescale 1ns/1ps
module tb_frame_scan_addr_gen;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          pix32 = 1'b0;
    logic          vsync = 1'b0;
    logic          fifo_clr = 1'b0;
    logic          next_we = 1'b0;
    logic [AW-1:0] next_base_in = '0;
    logic          xfer_we = 1'b0;
    logic [31:0]   xfer_cnt = '0;
    logic [AW-1:0] cur_base;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [AW-1:0] rd_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    frame_scan_addr_gen #(.AW(AW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .pix32        (pix32),
        .vsync        (vsync),
        .fifo_clr     (fifo_clr),
        .next_we      (next_we),
        .next_base_in (next_base_in),
        .xfer_we      (xfer_we),
        .xfer_cnt     (xfer_cnt),
        .cur_base     (cur_base),
        .rd_valid     (rd_valid),
        .rd_ready     (rd_ready),
        .rd_addr      (rd_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int unsigned h,
                                             input bit wide, input int unsigned n);
        int unsigned wpl, ln, c, stride;
        wpl    = wide ? h : (h + 1) / 2;
        stride = wide ? h * 4 : h * 2;
        ln     = n / wpl;
        c      = n % wpl;
        return ((base + ln * stride) & 32'hFFFF_FFFC) + 4 * c;
    endfunction

    function automatic bit ready_pat(input int mode, input int cyc);
        case (mode)
            1:       return (cyc % 3) != 0;
            2:       return (cyc % 4) == 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic write_next(input logic [31:0] b);
        @(negedge clk); next_we = 1'b1; next_base_in = b;
        @(negedge clk); next_we = 1'b0;
    endtask

    task automatic write_xfer(input int unsigned h, input int unsigned v);
        @(negedge clk); xfer_we = 1'b1; xfer_cnt = {v[15:0], h[15:0]};
        @(negedge clk); xfer_we = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync = 1'b1; rd_ready = 1'b0;
        @(negedge clk); vsync = 1'b0;
    endtask

    task automatic quiet(input string req, input int n);
        bit seen;
        seen = 1'b0;
        rd_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5;
            if (rd_valid) seen = 1'b1;
        end
        rd_ready = 1'b0;
        chk(!seen, req, {31'd0, seen}, 32'd0);
    endtask

    // accepts one whole frame and compares each address in order
    task automatic collect(input string req, input logic [31:0] base, input int unsigned h,
                           input int unsigned v, input bit wide, input int mode);
        int unsigned wpl, total, n, limit, cyc;
        logic [31:0] e;
        wpl   = wide ? h : (h + 1) / 2;
        total = wpl * v;
        limit = total * 6 + 40;
        n = 0; cyc = 0;
        while (n < total && cyc < limit) begin
            @(negedge clk);
            rd_ready = ready_pat(mode, int'(cyc));
            #0.5;
            if (rd_valid && rd_ready) begin
                e = exp_addr(base, h, wide, n);
                chk(rd_addr == e, req, rd_addr, e);
                n++;
            end
            cyc++;
        end
        rd_ready = 1'b0;
        chk(n == total, {req, " word count"}, n, total);
        quiet({req, " frame end"}, 12);
    endtask

    task automatic t_reset();
        #0.5;
        chk(rd_valid == 1'b0, "R11 valid after reset", {31'd0, rd_valid}, 32'd0);
        chk(cur_base == 32'd0, "R11 cur_base after reset", cur_base, 32'd0);
    endtask

    task automatic t_defer();
        write_next(32'h1000);
        repeat (3) @(negedge clk);
        chk(cur_base == 32'd0, "R1 cur_base before vsync", cur_base, 32'd0);
        pulse_vsync();
        chk(cur_base == 32'h1000, "R2 cur_base after vsync (run low)", cur_base, 32'h1000);
        @(negedge clk); vsync = 1'b1; next_we = 1'b1; next_base_in = 32'h1800;
        @(negedge clk); vsync = 1'b0; next_we = 1'b0;
        chk(cur_base == 32'h1000, "R2 same-cycle write deferred", cur_base, 32'h1000);
        pulse_vsync();
        chk(cur_base == 32'h1800, "R2 deferred write applied", cur_base, 32'h1800);
    endtask

    task automatic t_frame32();
        run = 1'b1; pix32 = 1'b1;
        write_xfer(3, 2);
        write_next(32'h4000);
        pulse_vsync();
        collect("R3 R4 R5 32-bit 3x2", 32'h4000, 3, 2, 1'b1, 0);
    endtask

    task automatic t_frame16_odd();
        pix32 = 1'b0;
        write_xfer(3, 3);
        write_next(32'h1000);
        pulse_vsync();
        collect("R4 R5 16-bit odd width 3x3", 32'h1000, 3, 3, 1'b0, 0);
    endtask

    task automatic t_backpressure();
        pix32 = 1'b0;
        write_xfer(8, 3);
        write_next(32'h8000);
        pulse_vsync();
        collect("R6 throttled ready 1", 32'h8000, 8, 3, 1'b0, 1);
        pulse_vsync();
        collect("R6 R10 throttled ready 2, base reused", 32'h8000, 8, 3, 1'b0, 2);
        chk(cur_base == 32'h8000, "R10 cur_base reloaded", cur_base, 32'h8000);
    endtask

    task automatic t_pan();
        pix32 = 1'b1;
        write_xfer(8, 3);
        write_next(32'h8000 + 32 * 2);
        pulse_vsync();
        collect("R5 vertical pan by two lines", 32'h8040, 8, 3, 1'b1, 0);
    endtask

    task automatic t_restart();
        pix32 = 1'b1;
        write_xfer(8, 4);
        write_next(32'h2000);
        pulse_vsync();
        repeat (4) @(negedge clk);
        write_next(32'h3000);
        pulse_vsync();
        collect("R7 restart mid-frame", 32'h3000, 8, 4, 1'b1, 0);
    endtask

    task automatic t_xfer_latch();
        pix32 = 1'b1;
        write_xfer(4, 2);
        write_next(32'h6000);
        pulse_vsync();
        repeat (2) @(negedge clk);
        write_xfer(16, 16);
        pix32 = 1'b0;
        collect("R3 shape held during frame", 32'h6000, 4, 2, 1'b1, 0);
        write_xfer(2, 1);
        pulse_vsync();
        collect("R3 new shape at next frame", 32'h6000, 2, 1, 1'b0, 0);
    endtask

    task automatic t_clear();
        pix32 = 1'b1;
        write_xfer(8, 8);
        write_next(32'h9000);
        pulse_vsync();
        rd_ready = 1'b1;
        repeat (6) @(negedge clk);
        rd_ready = 1'b0; fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
        #0.5;
        chk(rd_valid == 1'b0, "R8 valid low after clear", {31'd0, rd_valid}, 32'd0);
        quiet("R8 no request after clear", 12);
        chk(cur_base == 32'h9000, "R8 cur_base kept by clear", cur_base, 32'h9000);
        write_xfer(2, 1);
        write_next(32'h7000);
        @(negedge clk); fifo_clr = 1'b1; vsync = 1'b1;
        @(negedge clk); fifo_clr = 1'b0; vsync = 1'b0;
        chk(cur_base == 32'h7000, "R8 swap with clear+vsync", cur_base, 32'h7000);
        quiet("R8 clear wins over vsync", 12);
        pulse_vsync();
        collect("R8 recovery at next vsync", 32'h7000, 2, 1, 1'b1, 0);
    endtask

    task automatic t_idle();
        run = 1'b0;
        write_next(32'h5000);
        pulse_vsync();
        quiet("R9 run low starts no frame", 12);
        chk(cur_base == 32'h5000, "R9 R2 swap while run low", cur_base, 32'h5000);
        run = 1'b1;
        write_xfer(0, 5);
        pulse_vsync();
        quiet("R9 zero width", 12);
        write_xfer(4, 0);
        pulse_vsync();
        quiet("R9 zero height", 12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_defer();
        t_frame32();
        t_frame16_odd();
        t_backpressure();
        t_pan();
        t_restart();
        t_xfer_latch();
        t_clear();
        t_idle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule